// File: doc/BRIEF.md
# Immediate Prefix Operand Builder

This block produces the registered B operand of a small 16-bit pipelined processor. In each pipeline advance it loads either the B-port register value or an immediate taken from the decode-stage instruction word. The immediate can be a 12-bit field placed above a zero nibble, a sign-extended 4-bit field, a zero-extended 4-bit field, or a sign-extended 4-bit field scaled by two for word addressing.

The operand register is split into two parts that have separate clock enables. The low nibble loads on every pipeline advance. The upper twelve bits also load on every advance, except when the instruction now in the execute stage is the immediate prefix. In that case they keep their value. The prefix instruction loads its 12-bit field into the upper part while it sits in decode. The instruction that follows it then adds only the low nibble, which gives a full 16-bit immediate built from two instructions. A call instruction uses the same 12-bit placement, so its target is r0 plus the field times 16.

The instruction word uses bits 11:0 as the 12-bit immediate field and bits 3:0 as the 4-bit immediate field. Decoding the opcode and computing in the ALU are done outside this block.

Top module: `prefix_operand_builder`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and for the two clocks after it is released, the operand output is 0x0000.
- R2: In a cycle where pipeline enable is low, all 16 operand bits keep their value.
- R3: With pipeline enable high and no immediate control set, the operand loads the B-port register data (all 16 bits when no prefix is in execute).
- R4: With the 12-bit control set, the operand loads instruction bits 11:0 into bits 15:4 and zero into bits 3:0.
- R5: With the sign-extended 4-bit control set and no prefix in execute, bits 3:0 load instruction bits 3:0 and bits 15:4 all copy instruction bit 3.
- R6: With the plain 4-bit control set and no prefix in execute, bits 3:0 load instruction bits 3:0 and bits 15:4 load zero.
- R7: With the word control set and no prefix in execute, the operand loads instruction bits 3:0 as a signed value times two (bit 0 zero, bits 3:1 from instruction bits 2:0, bits 15:4 copying instruction bit 3).
- R8: With pipeline enable high and the execute-stage prefix indication high, bits 15:4 keep their value and bits 3:0 load the low nibble of the selected source.
- R9: When several controls are set, precedence is 12-bit, then word, then sign-extended 4-bit, then plain 4-bit, then register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| pipe_ce | input | 1 | Pipeline advance enable |
| ex_is_prefix | input | 1 | Execute-stage instruction is the immediate prefix |
| dc_instr | input | 16 | Decode-stage instruction word |
| breg_data | input | 16 | B-port register file data |
| use_imm12 | input | 1 | Select 12-bit immediate shifted left by four |
| use_word | input | 1 | Select signed 4-bit immediate times two |
| use_sext4 | input | 1 | Select sign-extended 4-bit immediate |
| use_imm4 | input | 1 | Select zero-extended 4-bit immediate |
| b_operand | output | 16 | Registered B operand |

## Verification
The assertions check on every cycle that a stalled pipeline changes nothing. They also check that a prefix in execute freezes the upper twelve bits, and that the register, 12-bit and sign-extended selections give the exact upper and lower values. Only the bench's scenarios show the complete effect of a prefix: a prefix in decode followed by a sign-extended, zero-extended or register instruction, which gives a joined 16-bit value. The bench also covers the precedence between controls that are set together and the value held through reset release.

// File: rtl/bop_pkg.sv
package bop_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned HI_W   = WORD_W - NIB_W;

  typedef enum logic [2:0] {
    SRC_REG   = 3'd0,
    SRC_IMM4  = 3'd1,
    SRC_SEXT4 = 3'd2,
    SRC_WORD  = 3'd3,
    SRC_IMM12 = 3'd4
  } bop_src_e;
endpackage

// File: rtl/bop_src_select.sv
module bop_src_select
  import bop_pkg::*;
(
  input  logic     use_imm12,
  input  logic     use_word,
  input  logic     use_sext4,
  input  logic     use_imm4,
  output bop_src_e src
);
  // Fixed precedence (R9): imm12, word, sext4, imm4, register.
  always_comb begin
    if (use_imm12)      src = SRC_IMM12;
    else if (use_word)  src = SRC_WORD;
    else if (use_sext4) src = SRC_SEXT4;
    else if (use_imm4)  src = SRC_IMM4;
    else                src = SRC_REG;
  end
endmodule

// File: rtl/bop_value_build.sv
module bop_value_build
  import bop_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned LW = NIB_W,
  localparam int unsigned HW = DW - LW
) (
  input  bop_src_e          src,
  input  logic [DW-1:0]     instr,
  input  logic [DW-1:0]     breg,
  output logic [HW-1:0]     hi_next,
  output logic [LW-1:0]     lo_next
);
  logic          sgn;
  logic [LW-1:0] nib;
  logic [LW-1:0] nib_x2;

  assign nib    = instr[LW-1:0];
  assign sgn    = instr[LW-1];
  assign nib_x2 = {instr[LW-2:0], 1'b0};

  always_comb begin
    unique case (src)
      SRC_IMM12: begin
        hi_next = instr[HW-1:0];
        lo_next = '0;
      end
      SRC_WORD: begin
        hi_next = {HW{sgn}};
        lo_next = nib_x2;
      end
      SRC_SEXT4: begin
        hi_next = {HW{sgn}};
        lo_next = nib;
      end
      SRC_IMM4: begin
        hi_next = '0;
        lo_next = nib;
      end
      default: begin
        hi_next = breg[DW-1:LW];
        lo_next = breg[LW-1:0];
      end
    endcase
  end
endmodule

// File: rtl/bop_field_reg.sv
module bop_field_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ce) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/prefix_operand_builder.sv
module prefix_operand_builder
  import bop_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned LW = NIB_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          pipe_ce,
  input  logic          ex_is_prefix,
  input  logic [DW-1:0] dc_instr,
  input  logic [DW-1:0] breg_data,
  input  logic          use_imm12,
  input  logic          use_word,
  input  logic          use_sext4,
  input  logic          use_imm4,
  output logic [DW-1:0] b_operand
);
  localparam int unsigned HW = DW - LW;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   srst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = rst_pipe[SYNC_STAGES-1];

  bop_src_e      src;
  logic [HW-1:0] hi_next, hi_q;
  logic [LW-1:0] lo_next, lo_q;
  logic          hi_ce, lo_ce;

  bop_src_select u_sel (
    .use_imm12 (use_imm12),
    .use_word  (use_word),
    .use_sext4 (use_sext4),
    .use_imm4  (use_imm4),
    .src       (src)
  );

  bop_value_build #(.DW(DW), .LW(LW)) u_build (
    .src     (src),
    .instr   (dc_instr),
    .breg    (breg_data),
    .hi_next (hi_next),
    .lo_next (lo_next)
  );

  // Low nibble advances on every pipeline step; upper part waits out a prefix.
  assign lo_ce = pipe_ce;
  assign hi_ce = pipe_ce & ~ex_is_prefix;

  bop_field_reg #(.W(LW)) u_lo (
    .clk (clk), .rst_n (srst_n), .ce (lo_ce), .d (lo_next), .q (lo_q)
  );

  bop_field_reg #(.W(HW)) u_hi (
    .clk (clk), .rst_n (srst_n), .ce (hi_ce), .d (hi_next), .q (hi_q)
  );

  assign b_operand = {hi_q, lo_q};

  assert_stall_holds_R2: assert property (@(posedge clk) disable iff (!srst_n)
    !pipe_ce |=> $stable(b_operand));

  assert_prefix_holds_hi_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (pipe_ce && ex_is_prefix) |=> $stable(b_operand[DW-1:LW]));

  assert_reg_load_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (pipe_ce && !ex_is_prefix && !use_imm12 && !use_word && !use_sext4 && !use_imm4)
    |=> (b_operand == $past(breg_data)));

  assert_imm12_place_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (pipe_ce && !ex_is_prefix && use_imm12)
    |=> (b_operand == {$past(dc_instr[HW-1:0]), {LW{1'b0}}}));

  assert_sext_upper_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (pipe_ce && !ex_is_prefix && !use_imm12 && !use_word && use_sext4)
    |=> (b_operand == {{HW{$past(dc_instr[LW-1])}}, $past(dc_instr[LW-1:0])}));
endmodule

// File: tb/prefix_operand_builder_test.sv
module prefix_operand_builder_test;
  logic        clk = 1'b0;
  logic        arst_n;
  logic        pipe_ce;
  logic        ex_is_prefix;
  logic [15:0] dc_instr;
  logic [15:0] breg_data;
  logic        use_imm12, use_word, use_sext4, use_imm4;
  logic [15:0] b_operand;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = 16'h0000;

  always #2.5 clk = ~clk;

  prefix_operand_builder uut (
    .clk (clk), .arst_n (arst_n), .pipe_ce (pipe_ce),
    .ex_is_prefix (ex_is_prefix), .dc_instr (dc_instr),
    .breg_data (breg_data), .use_imm12 (use_imm12), .use_word (use_word),
    .use_sext4 (use_sext4), .use_imm4 (use_imm4), .b_operand (b_operand)
  );

  function automatic logic [15:0] pick(input logic [15:0] ins, input logic [15:0] rb,
                                       input logic [3:0] sel);
    int v;
    v = (ins[3] ? int'(ins[3:0]) - 16 : int'(ins[3:0]));
    if (sel[3])      return {ins[11:0], 4'h0};
    else if (sel[2]) return 16'(v * 2);
    else if (sel[1]) return 16'(v);
    else if (sel[0]) return {12'h000, ins[3:0]};
    else             return rb;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (b_operand !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, b_operand, exp);
    end
  endtask

  // sel = {imm12, word, sext4, imm4}
  task automatic step(input string req, input logic ce, input logic pfx,
                      input logic [15:0] ins, input logic [15:0] rb, input logic [3:0] sel);
    logic [15:0] full;
    pipe_ce = ce; ex_is_prefix = pfx; dc_instr = ins; breg_data = rb;
    {use_imm12, use_word, use_sext4, use_imm4} = sel;
    @(posedge clk);
    full = pick(ins, rb, sel);
    if (ce) begin
      model[3:0] = full[3:0];
      if (!pfx) model[15:4] = full[15:4];
    end
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; pipe_ce = 1'b0; ex_is_prefix = 1'b0;
    dc_instr = 16'h0; breg_data = 16'h0;
    {use_imm12, use_word, use_sext4, use_imm4} = 4'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 16'h0000);
    arst_n = 1'b1;
    // Enable held low during the sync window: output must stay zero.
    step("R1 after release", 1'b0, 1'b0, 16'hFFFF, 16'hBEEF, 4'b0000);
    step("R1 after release", 1'b0, 1'b0, 16'hFFFF, 16'hBEEF, 4'b0000);

    step("R3 register", 1'b1, 1'b0, 16'h0000, 16'hA5C3, 4'b0000);
    step("R2 stall", 1'b0, 1'b0, 16'h0ABC, 16'h1234, 4'b1000);
    step("R2 stall", 1'b0, 1'b1, 16'h0007, 16'h5678, 4'b0010);
    step("R4 imm12", 1'b1, 1'b0, 16'hF123, 16'h0000, 4'b1000);
    step("R5 sext4 negative", 1'b1, 1'b0, 16'h00F9, 16'h0000, 4'b0010);
    step("R5 sext4 positive", 1'b1, 1'b0, 16'h0006, 16'hFFFF, 4'b0010);
    step("R6 imm4", 1'b1, 1'b0, 16'h000C, 16'hFFFF, 4'b0001);
    step("R7 word negative", 1'b1, 1'b0, 16'h000B, 16'h0000, 4'b0100);
    step("R7 word positive", 1'b1, 1'b0, 16'h0005, 16'h0000, 4'b0100);

    // Prefix in decode, then dependent instruction with prefix in execute.
    step("R4 prefix in decode", 1'b1, 1'b0, 16'h8ABC, 16'h0000, 4'b1000);
    step("R8 prefix then sext4", 1'b1, 1'b1, 16'h000E, 16'h0000, 4'b0010);
    step("R4 prefix in decode", 1'b1, 1'b0, 16'h8123, 16'h0000, 4'b1000);
    step("R8 prefix then imm4", 1'b1, 1'b1, 16'h0009, 16'hFFFF, 4'b0001);
    step("R4 prefix in decode", 1'b1, 1'b0, 16'h8FED, 16'h0000, 4'b1000);
    step("R8 prefix then register", 1'b1, 1'b1, 16'h0000, 16'h7773, 4'b0000);
    step("R4 prefix in decode", 1'b1, 1'b0, 16'h8456, 16'h0000, 4'b1000);
    step("R2 stall between prefix pair", 1'b0, 1'b1, 16'h0001, 16'h0000, 4'b0001);
    step("R8 prefix then word", 1'b1, 1'b1, 16'h000F, 16'h0000, 4'b0100);

    step("R9 imm12 over all", 1'b1, 1'b0, 16'h0F37, 16'h1111, 4'b1111);
    step("R9 word over sext4", 1'b1, 1'b0, 16'h0009, 16'h1111, 4'b0111);
    step("R9 sext4 over imm4", 1'b1, 1'b0, 16'h000A, 16'h1111, 4'b0011);
    step("R3 register again", 1'b1, 1'b0, 16'hFFFF, 16'h0F0F, 4'b0000);

    for (int i = 0; i < 40; i++) begin
      logic [3:0] s;
      logic       p;
      s = 4'(i * 7 + 3);
      p = (i % 5 == 2);
      step("R9 mixed sequence", (i % 6 != 4), p, 16'(i * 16'h3B1D), 16'(i * 16'h59A7), s);
    end

    arst_n = 1'b0;
    model = 16'h0000;
    #1;
    check("R1 reassert", 16'h0000);
    @(negedge clk);
    arst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule